// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block turns the two phase outputs of an incremental encoder, or a plain clock and direction pair, into a signed position count. Two configuration bytes choose the decode resolution, the counting regime, what an index pulse does and at which level it is active, and the byte width of the count. A preset register supplies the value used for loads, compares and the limit of the bounded counting regimes. A snapshot register captures the count on request or on an index.

The count, the snapshot, a status byte and one flag line are the outputs. Carry, borrow, compare and index events set sticky bits in the status byte, which stay set until a clear-status strobe. The flag line is the OR of those bits, each one gated by its own enable bit in the second configuration byte.

Top module: `quad_counter`

## Requirements
- R1: `cfg_a[1:0]` picks the decode: 00 counts one step per rising edge of A, up when B is high and down when B is low; 01, 10 and 11 count 1, 2 and 4 steps per full quadrature cycle. The forward sequence of {A,B} is 00,10,11,01,00 and counts up. In x1 the only counted transitions are 00 to 10 (up) and 10 to 00 (down); in x2 every A transition counts.
- R2: A and B pass through a synchronizer and reach the count within four clock edges when `cfg_a[7]` is 0; with `cfg_a[7]` at 1 they are sampled every second cycle. A jump where A and B change together is not counted.
- R3: `cfg_b[1:0]` sets the width: 00 is 4 bytes, 01 is 3, 10 is 2, 11 is 1. The count, the preset used for loads and compares, and the wrap points all use that width.
- R4: With `cfg_a[3:2]` = 00 the count wraps freely; an up step from the all-ones value gives 0 and sets status bit 7 (carry), and a down step from 0 gives all ones and sets status bit 6 (borrow).
- R5: With `cfg_a[3:2]` = 01 the counter wraps as in R4 and then halts on that carry or borrow, until a counter clear or load (by strobe or by index) lets it count again.
- R6: With `cfg_a[3:2]` = 10 the count stays between 0 and the preset. An up step at the preset, or a down step at 0, leaves the count unchanged and sets carry or borrow. Counting resumes as soon as the direction reverses.
- R7: With `cfg_a[3:2]` = 11 the count cycles through preset+1 states. An up step at the preset gives 0 and sets carry, and a down step at 0 gives the preset and sets borrow.
- R8: `cfg_a[5:4]` picks the index action: 00 none, 01 load the count from the preset, 10 clear the count, 11 copy the count into `snap_val` with the count unchanged. `cfg_a[6]` = 1 makes the index active high, 0 active low. The action fires once on entry to the active level and sets status bit 4.
- R9: In a quadrature decode an index is accepted only while A equals B. In the clock/direction decode it is accepted whatever A and B are.
- R10: Steps are counted only while `cnt_en` is 1 and `cfg_b[2]` is 0. Status bit 3 reads 1 exactly when both hold.
- R11: Status layout: bit7 carry, bit6 borrow, bit5 compare, bit4 index, bit3 count enable, bit2 power-loss (1 after reset), bit1 last direction (1 = up), bit0 receive error (always 0). After reset the status reads 0x04 with `cnt_en` low. Bits 7, 6, 5, 4 and 2 clear only on `clr_stat`, and an event in the same cycle as `clr_stat` leaves its bit set.
- R12: `flag` is 1 when any of status bits 7, 6, 5, 4 is set and its enable `cfg_b[7]`, `cfg_b[6]`, `cfg_b[5]`, `cfg_b[4]` is set (`cfg_b[3]` enables bit 0).
- R13: Status bit 5 sets whenever the count is written (step, load or clear) with a value equal to the preset.
- R14: `clr_cnt` takes priority over `ld_cnt`, and both take priority over an index action and a step. `snap` copies the count into `snap_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | Encoder phase A, or the count clock |
| b_in | input | 1 | Encoder phase B, or the direction |
| idx_in | input | 1 | Index marker |
| cnt_en | input | 1 | External count enable |
| cfg_a | input | 8 | Decode, regime, index action, index polarity, sampling divide |
| cfg_b | input | 8 | Width, count disable, flag enables |
| pre_wr | input | 1 | Write strobe for the preset register |
| pre_din | input | CW | Preset value |
| clr_cnt | input | 1 | Clear the count |
| ld_cnt | input | 1 | Load the count from the preset |
| snap | input | 1 | Copy the count into the snapshot |
| clr_stat | input | 1 | Clear the sticky status bits |
| count | output | CW | Count at the selected width |
| snap_val | output | CW | Snapshot register |
| status | output | 8 | Status byte |
| flag | output | 1 | Masked OR of the sticky events |

## Verification
Full quadrature cycles are run in both directions in every decode, so x1, x2 and x4 are told apart by the count they yield from the same edge sequence. Direction errors show up as a wrong sign. The width and the sampling divide are varied in the same table. Short step runs near the all-ones value, at zero and at the preset separate the four regimes by where the count wraps, sticks or halts. Index pulses given at equal and unequal A/B levels, at both polarities, show the gating and each of the three actions.

// File: rtl/quad_counter.sv
`timescale 1ns/1ps
module quad_counter #(
  parameter int BYTES = 4,
  parameter int SYNC  = 2,
  localparam int CW   = 8 * BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_in,
  input  logic          b_in,
  input  logic          idx_in,
  input  logic          cnt_en,
  input  logic [7:0]    cfg_a,
  input  logic [7:0]    cfg_b,
  input  logic          pre_wr,
  input  logic [CW-1:0] pre_din,
  input  logic          clr_cnt,
  input  logic          ld_cnt,
  input  logic          snap,
  input  logic          clr_stat,
  output logic [CW-1:0] count,
  output logic [CW-1:0] snap_val,
  output logic [7:0]    status,
  output logic          flag
);

  logic [SYNC-1:0] a_sh, b_sh, i_sh;
  logic            tick_q;
  logic [1:0]      ab_q;
  logic            g_q;
  logic [CW-1:0]   cnt_q, pre_q, otr_q;
  logic            halt_q, dir_q;
  logic            cy_q, bw_q, cmp_q, ix_q, pl_q;

  wire samp = ~cfg_a[7] | tick_q;
  wire a_s = a_sh[SYNC-1];
  wire b_s = b_sh[SYNC-1];
  wire i_s = i_sh[SYNC-1];
  wire [1:0] ab = {a_s, b_s};
  wire [1:0] fn = cfg_a[5:4];

  logic [CW-1:0] wmask;
  int nb;
  always_comb begin
    nb = 4 - int'(cfg_b[1:0]);
    wmask = '0;
    for (int i = 0; i < BYTES; i++)
      if (i < nb) wmask[8*i +: 8] = 8'hFF;
  end

  wire [CW-1:0] c = cnt_q & wmask;
  wire [CW-1:0] d = pre_q & wmask;

  wire fwd = (ab_q == 2'b00 && ab == 2'b10) || (ab_q == 2'b10 && ab == 2'b11) ||
             (ab_q == 2'b11 && ab == 2'b01) || (ab_q == 2'b01 && ab == 2'b00);
  wire rev = (ab_q == 2'b00 && ab == 2'b01) || (ab_q == 2'b01 && ab == 2'b11) ||
             (ab_q == 2'b11 && ab == 2'b10) || (ab_q == 2'b10 && ab == 2'b00);
  wire x1u = ab_q == 2'b00 && ab == 2'b10;
  wire x1d = ab_q == 2'b10 && ab == 2'b00;

  logic step, up;
  always_comb begin
    case (cfg_a[1:0])
      2'b00:   begin step = a_s & ~ab_q[1];                     up = b_s; end
      2'b01:   begin step = x1u | x1d;                          up = x1u; end
      2'b10:   begin step = (fwd | rev) & (ab_q[1] ^ a_s);      up = fwd; end
      default: begin step = fwd | rev;                          up = fwd; end
    endcase
  end

  wire gate = (cfg_a[6] ? i_s : ~i_s) & ((cfg_a[1:0] == 2'b00) | (a_s == b_s));
  wire idx_evt = gate & ~g_q & (fn != 2'b00);

  wire run = cnt_en & ~cfg_b[2];
  wire do_step = step & run & ~halt_q;

  logic [CW-1:0] nxt;
  logic cy_e, bw_e;
  always_comb begin
    nxt = c; cy_e = 1'b0; bw_e = 1'b0;
    if (up) begin
      case (cfg_a[3:2])
        2'b10:   if (c >= d) cy_e = 1'b1; else nxt = c + CW'(1);
        2'b11:   if (c >= d) begin nxt = '0; cy_e = 1'b1; end else nxt = c + CW'(1);
        default: if (c == wmask) begin nxt = '0; cy_e = 1'b1; end else nxt = c + CW'(1);
      endcase
    end else begin
      case (cfg_a[3:2])
        2'b10:   if (c == '0) bw_e = 1'b1; else nxt = c - CW'(1);
        2'b11:   if (c == '0) begin nxt = d; bw_e = 1'b1; end else nxt = c - CW'(1);
        default: if (c == '0) begin nxt = wmask; bw_e = 1'b1; end else nxt = c - CW'(1);
      endcase
    end
  end

  logic [CW-1:0] cnt_d;
  logic wr, ld_any, cy_set, bw_set;
  always_comb begin
    cnt_d = cnt_q; wr = 1'b0; ld_any = 1'b0; cy_set = 1'b0; bw_set = 1'b0;
    if (clr_cnt) begin
      cnt_d = '0; wr = 1'b1; ld_any = 1'b1;
    end else if (ld_cnt) begin
      cnt_d = d; wr = 1'b1; ld_any = 1'b1;
    end else if (idx_evt && fn == 2'b01) begin
      cnt_d = d; wr = 1'b1; ld_any = 1'b1;
    end else if (idx_evt && fn == 2'b10) begin
      cnt_d = '0; wr = 1'b1; ld_any = 1'b1;
    end else if (do_step) begin
      cnt_d = nxt; wr = 1'b1; cy_set = cy_e; bw_set = bw_e;
    end
  end

  wire cmp_set = wr & ((cnt_d & wmask) == d);
  wire single = cfg_a[3:2] == 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      a_sh <= '0; b_sh <= '0; i_sh <= '0;
      ab_q <= 2'b00; g_q <= 1'b0;
    end else begin
      tick_q <= ~tick_q;
      if (samp) begin
        a_sh <= {a_sh[SYNC-2:0], a_in};
        b_sh <= {b_sh[SYNC-2:0], b_in};
        i_sh <= {i_sh[SYNC-2:0], idx_in};
      end
      ab_q <= ab;
      g_q <= gate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; pre_q <= '0; otr_q <= '0;
      halt_q <= 1'b0; dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (pre_wr) pre_q <= pre_din;
      if (snap || (idx_evt && fn == 2'b11)) otr_q <= c;
      if (ld_any || !single) halt_q <= 1'b0;
      else if (cy_set || bw_set) halt_q <= 1'b1;
      if (do_step) dir_q <= up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0; bw_q <= 1'b0; cmp_q <= 1'b0; ix_q <= 1'b0; pl_q <= 1'b1;
    end else begin
      cy_q  <= (cy_q  & ~clr_stat) | cy_set;
      bw_q  <= (bw_q  & ~clr_stat) | bw_set;
      cmp_q <= (cmp_q & ~clr_stat) | cmp_set;
      ix_q  <= (ix_q  & ~clr_stat) | idx_evt;
      pl_q  <= pl_q & ~clr_stat;
    end
  end

  assign count    = c;
  assign snap_val = otr_q & wmask;
  assign status   = {cy_q, bw_q, cmp_q, ix_q, run, pl_q, dir_q, 1'b0};
  assign flag     = |(status[7:4] & cfg_b[7:4]) | (status[0] & cfg_b[3]);

endmodule

// File: rtl/quad_counter_chk.sv
`timescale 1ns/1ps
module quad_counter_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic [7:0]    cfg_a,
  input logic [7:0]    cfg_b,
  input logic          clr_cnt,
  input logic          ld_cnt,
  input logic          clr_stat,
  input logic [CW-1:0] pre_q,
  input logic [CW-1:0] count,
  input logic [7:0]    status,
  input logic          flag
);

  logic [CW-1:0] m;
  always_comb begin
    m = '0;
    for (int i = 0; i < CW/8; i++)
      if (i < 4 - int'(cfg_b[1:0])) m[8*i +: 8] = 8'hFF;
  end
  wire [CW-1:0] lim = pre_q & m;

  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ld_cnt && !clr_cnt && (cfg_a[5:4] == 2'b00 || cfg_a[5:4] == 2'b11))
    |=> ($stable(count) || !$stable(cfg_b)));

  a_r6_range_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a[3:2] == 2'b10 && count <= lim)
    |=> (count <= lim || !$stable(cfg_a) || !$stable(cfg_b) || !$stable(pre_q)));

  a_r7_modulo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a[3:2] == 2'b11 && count <= lim)
    |=> (count <= lim || !$stable(cfg_a) || !$stable(cfg_b) || !$stable(pre_q)));

  a_r11_sticky_events: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stat |=> ((status[7:4] & $past(status[7:4])) == $past(status[7:4])));

  a_r11_power_loss_once: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2] |=> !status[2]);

  a_r12_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (|(status[7:4] & cfg_b[7:4])));

endmodule

bind quad_counter quad_counter_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_a(cfg_a), .cfg_b(cfg_b),
  .clr_cnt(clr_cnt), .ld_cnt(ld_cnt), .clr_stat(clr_stat), .pre_q(pre_q),
  .count(count), .status(status), .flag(flag)
);

// File: tb/quad_counter_tb_top.sv
`timescale 1ns/1ps
module quad_counter_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, a_in, b_in, idx_in, cnt_en, pre_wr, clr_cnt, ld_cnt, snap, clr_stat;
  logic [7:0] cfg_a, cfg_b;
  logic [31:0] pre_din, count, snap_val;
  logic [7:0] status;
  logic flag;

  quad_counter dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .idx_in(idx_in),
    .cnt_en(cnt_en), .cfg_a(cfg_a), .cfg_b(cfg_b), .pre_wr(pre_wr), .pre_din(pre_din),
    .clr_cnt(clr_cnt), .ld_cnt(ld_cnt), .snap(snap), .clr_stat(clr_stat),
    .count(count), .snap_val(snap_val), .status(status), .flag(flag)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] ab_cur;

  typedef struct packed {
    logic [7:0]  m0;
    logic [7:0]  m1;
    logic [3:0]  ncyc;
    logic        up;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 8'h00, 4'd3, 1'b1, 32'd12},
    '{8'h02, 8'h00, 4'd3, 1'b1, 32'd6},
    '{8'h01, 8'h00, 4'd3, 1'b1, 32'd3},
    '{8'h03, 8'h00, 4'd2, 1'b0, 32'hFFFF_FFF8},
    '{8'h00, 8'h00, 4'd5, 1'b1, 32'd5},
    '{8'h00, 8'h00, 4'd3, 1'b0, 32'hFFFF_FFFD},
    '{8'h03, 8'h03, 4'd1, 1'b0, 32'h0000_00FC},
    '{8'h83, 8'h00, 4'd2, 1'b1, 32'd8},
    '{8'h01, 8'h00, 4'd2, 1'b0, 32'hFFFF_FFFE},
    '{8'h02, 8'h02, 4'd1, 1'b0, 32'h0000_FFFE}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] fstep(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rstep(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic set_ab(input logic [1:0] v);
    a_in = v[1]; b_in = v[0]; ab_cur = v;
    cyc(8);
  endtask

  task automatic step_up(input int n);
    for (int i = 0; i < n; i++) set_ab(fstep(ab_cur));
  endtask

  task automatic step_dn(input int n);
    for (int i = 0; i < n; i++) set_ab(rstep(ab_cur));
  endtask

  task automatic nq_pulse(input int n, input logic dir);
    for (int i = 0; i < n; i++) begin
      b_in = dir; cyc(8);
      a_in = 1'b1; cyc(8);
      a_in = 1'b0; cyc(8);
    end
    ab_cur = {1'b0, dir};
  endtask

  task automatic ctl(input logic c, input logic l, input logic s, input logic cs);
    clr_cnt = c; ld_cnt = l; snap = s; clr_stat = cs;
    cyc(1);
    clr_cnt = 0; ld_cnt = 0; snap = 0; clr_stat = 0;
    cyc(1);
  endtask

  task automatic wr_pre(input logic [31:0] v);
    pre_din = v; pre_wr = 1'b1; cyc(1);
    pre_wr = 1'b0; cyc(1);
  endtask

  task automatic idx_pulse(input logic act);
    idx_in = act; cyc(8);
    idx_in = ~act; cyc(8);
  endtask

  task automatic go_home();
    cfg_a = 8'h00; cyc(2);
    set_ab(2'b00);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_in = 0; b_in = 0; idx_in = 0; cnt_en = 0; pre_wr = 0; pre_din = 0;
    clr_cnt = 0; ld_cnt = 0; snap = 0; clr_stat = 0; cfg_a = 0; cfg_b = 0; ab_cur = 0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    check("R11 reset status", {24'd0, status}, 32'h04);
    check("R11 reset count", count, 0);
    check("R12 reset flag", {31'd0, flag}, 0);
    check("R14 reset snapshot", snap_val, 0);

    cnt_en = 1;
    for (int i = 0; i < NV; i++) begin
      go_home();
      cfg_a = VECS[i].m0; cfg_b = VECS[i].m1; cyc(4);
      ctl(1, 0, 0, 0);
      if (VECS[i].m0[1:0] == 2'b00) nq_pulse(int'(VECS[i].ncyc), VECS[i].up);
      else if (VECS[i].up) step_up(4 * int'(VECS[i].ncyc));
      else step_dn(4 * int'(VECS[i].ncyc));
      check($sformatf("R1 R3 vector %0d", i), count, VECS[i].exp);
    end

    go_home();
    cfg_a = 8'h03; cfg_b = 8'h00; cyc(2);
    ctl(1, 0, 0, 0);
    set_ab(2'b11);
    check("R2 double transition ignored", count, 0);
    set_ab(2'b00);
    check("R2 double transition back ignored", count, 0);

    cnt_en = 0;
    step_up(3);
    check("R10 input disable", count, 0);
    check("R10 status enable bit low", {31'd0, status[3]}, 0);
    cnt_en = 1; cfg_b = 8'h04; cyc(2);
    step_up(2);
    check("R10 mode disable", count, 0);
    check("R10 status enable bit mode", {31'd0, status[3]}, 0);
    cfg_b = 8'h00; cyc(2);
    check("R10 status enable bit high", {31'd0, status[3]}, 1);

    ctl(0, 0, 0, 1);
    check("R11 power-loss cleared", {31'd0, status[2]}, 0);
    wr_pre(32'hFFFF_FFFF);
    ctl(0, 1, 0, 1);
    step_up(1);
    check("R4 carry wrap", count, 0);
    check("R4 carry bit", {31'd0, status[7]}, 1);
    check("R11 direction up", {31'd0, status[1]}, 1);
    cfg_b = 8'h40; cyc(2);
    check("R12 flag masked", {31'd0, flag}, 0);
    cfg_b = 8'h80; cyc(2);
    check("R12 flag enabled", {31'd0, flag}, 1);
    cfg_b = 8'h00;
    ctl(0, 0, 0, 1);
    step_dn(1);
    check("R4 borrow wrap", count, 32'hFFFF_FFFF);
    check("R4 borrow bit", {31'd0, status[6]}, 1);
    check("R11 direction down", {31'd0, status[1]}, 0);

    cfg_b = 8'h03; ctl(1, 0, 0, 1);
    step_dn(1);
    check("R3 one-byte borrow", count, 32'hFF);
    step_up(1);
    check("R3 one-byte carry", count, 0);
    cfg_b = 8'h00;

    cfg_a = 8'h0F; wr_pre(4);
    ctl(1, 0, 0, 1);
    step_up(7);
    check("R7 modulo up", count, 2);
    check("R7 modulo carry", {31'd0, status[7]}, 1);
    ctl(1, 0, 0, 1);
    step_dn(1);
    check("R7 modulo down wrap", count, 4);
    check("R7 modulo borrow", {31'd0, status[6]}, 1);

    cfg_a = 8'h0B; wr_pre(3);
    ctl(1, 0, 0, 1);
    step_up(6);
    check("R6 range upper hold", count, 3);
    check("R6 range carry", {31'd0, status[7]}, 1);
    step_dn(1);
    check("R6 range reverse", count, 2);
    step_dn(4);
    check("R6 range lower hold", count, 0);

    cfg_a = 8'h07; cfg_b = 8'h03; wr_pre(32'hFF);
    ctl(0, 1, 0, 1);
    step_up(1);
    check("R5 single wrap", count, 0);
    step_up(2);
    check("R5 single halted", count, 0);
    ctl(1, 0, 0, 0);
    step_up(1);
    check("R5 single restart", count, 1);
    cfg_b = 8'h00;

    go_home();
    cfg_a = 8'h53; wr_pre(32'h55);
    ctl(1, 0, 0, 1);
    idx_pulse(1'b1);
    check("R8 index load", count, 32'h55);
    check("R8 index bit", {31'd0, status[4]}, 1);
    ctl(1, 0, 0, 0);
    step_up(1);
    idx_pulse(1'b1);
    check("R9 index gated off", count, 1);
    step_up(1);
    idx_pulse(1'b1);
    check("R9 index at both high", count, 32'h55);
    cfg_a = 8'h63; cyc(2);
    idx_pulse(1'b1);
    check("R8 index clear", count, 0);
    cfg_a = 8'h73; cyc(2);
    step_up(2);
    idx_pulse(1'b1);
    check("R8 index snapshot", snap_val, 2);
    check("R8 snapshot keeps count", count, 2);
    cfg_a = 8'h03; idx_in = 1'b1; cyc(8);
    cfg_a = 8'h13; cyc(4);
    idx_pulse(1'b0);
    check("R8 active-low index load", count, 32'h55);
    cfg_a = 8'h03; idx_in = 1'b0; cyc(8);
    cfg_a = 8'h00; cyc(4);
    cfg_a = 8'h60; cyc(4);
    set_ab(2'b11);
    check("R1 clock-direction up", count, 32'h56);
    set_ab(2'b10);
    check("R1 clock-direction no A edge", count, 32'h56);
    idx_pulse(1'b1);
    check("R9 index ungated in clock-direction", count, 0);
    go_home();

    cfg_a = 8'h03; wr_pre(2);
    ctl(1, 0, 0, 1);
    step_up(2);
    check("R13 compare bit", {31'd0, status[5]}, 1);
    ctl(0, 0, 0, 1);
    check("R11 compare cleared", {31'd0, status[5]}, 0);
    ctl(0, 1, 0, 1);
    check("R11 event beats clear", {31'd0, status[5]}, 1);

    wr_pre(9);
    ctl(1, 1, 0, 0);
    check("R14 clear over load", count, 0);
    ctl(0, 1, 0, 0);
    check("R14 load", count, 9);
    ctl(0, 0, 1, 0);
    check("R14 snapshot strobe", snap_val, 9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule